// File: doc/BRIEF.md
# Sequential Flag-Offset Register File

This block keeps the two thresholds used by a FIFO's almost-empty and almost-full status logic. Each threshold is split over two byte-wide registers, a low part and a high part, so that software can load or inspect a threshold wider than the FIFO's nine-bit data path. The registers have no address. A two-bit pointer selects one of them, and every accepted access moves that pointer on to the next register.

While the active-low load strobe is held low, a write-enabled write-clock edge stores the data input into the selected register. A read-enabled read-clock edge copies the selected register to the readback output and pulses a valid flag. The pointer goes through the almost-empty threshold (low, then high) and then the almost-full threshold (low, then high), and after the fourth register it returns to the first. Releasing the strobe leaves the pointer where it is. The assembled thresholds are always present on two buses for the flag comparators.

The register file and its pointer are clocked by the write clock. The readback register is clocked by the read clock. Offset access assumes the two clocks are tied together, or that they are the same clock during a programming session.

Top module: `flag_ofs_regfile`

## Requirements
- R1: When `rst_n` is low at a clock edge, both low registers return to 007h, both high registers return to 000h, and the pointer returns to the almost-empty low register. As a result, `ae_off` = `af_off` = 7, `dout` = 0 and `dout_vld` = 0.
- R2: A write stores data at the pointer and then advances the pointer. The pointer order is 0 = almost-empty low, 1 = almost-empty high, 2 = almost-full low, 3 = almost-full high. The fifth consecutive write lands on almost-empty low again.
- R3: A write happens only when `ld_n` and `wen1_n` are both low at a rising `wr_clk` edge. With `ld_n` high, a low `wen1_n` changes no register and does not move the pointer.
- R4: A read happens only when `ld_n`, `ren1_n` and `ren2_n` are all low at a rising `rd_clk` edge. After that edge, `dout` holds the selected register and `dout_vld` is high for that one cycle.
- R5: Reads follow the same four-step order as writes and wrap in the same way. Reads and writes share one pointer, so a write after a read goes to the register after the one that was read.
- R6: Raising `ld_n` keeps the pointer where it is. The next access after `ld_n` goes low again uses the register that follows the last one accessed.
- R7: `ae_off` equals the almost-empty high register above the almost-empty low register (the low register in bits 8:0). `af_off` is built the same way from the almost-full pair.
- R8: A high register stores only the lowest ADDR_W-9 bits of `din` (8 bits by default). Its other bits read back as zero.
- R9: If a read and a write are requested in the same cycle, the write is done and the read is dropped. `dout_vld` stays low, `dout` keeps its value, and the pointer advances by one.
- R10: In any cycle without an accepted read, `dout` keeps its previous value and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; register file and pointer |
| rd_clk | input | 1 | Read clock; readback register |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Offset access strobe, active low |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| din | input | DATA_W | Data written into the selected register |
| dout | output | DATA_W | Readback of the last register read |
| dout_vld | output | 1 | High for one cycle after an accepted read |
| ae_off | output | ADDR_W | Almost-empty threshold |
| af_off | output | ADDR_W | Almost-full threshold |

## Verification
The pointer is not visible at the ports, and this is what makes the block hard to check. Its position can only be inferred from which register a later write or read touches. The stimulus therefore sets up a position on purpose with partial write bursts, lets the strobe idle for several cycles, and then reads or writes to show where the pointer resumed. It also mixes reads and writes in one burst, and it forces a colliding read-and-write cycle. A read placed right after the collision shows that the pointer moved exactly once.

// File: rtl/ofs_pkg.sv
// Shared definitions for the flag-offset register file.
package ofs_pkg;
    // Pointer positions; the order is the access sequence.
    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } ofs_sel_e;

    localparam int NUM_OFS_REGS = 4;
endpackage

// File: rtl/ofs_seq_ptr.sv
// Wrapping selection pointer over the four offset registers.
// Assumes: step is high for exactly one cycle per accepted access.
module ofs_seq_ptr
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_e sel
);
    logic [1:0] ptr_q;

    // Advance by one per accepted access, wrapping naturally at four.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= 2'd0;
        else if (step)
            ptr_q <= ptr_q + 2'd1;
    end

    assign sel = ofs_sel_e'(ptr_q);
endmodule

// File: rtl/ofs_reg_bank.sv
// Four offset registers; even slots are full-width low parts, odd slots
// keep only HI_W bits. Assumes we is already qualified by the load strobe.
module ofs_reg_bank
    import ofs_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 17,
    parameter int DEF_OFS = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  ofs_sel_e                             sel,
    input  logic [DATA_W-1:0]                    din,
    output logic [NUM_OFS_REGS-1:0][DATA_W-1:0]  regs
);
    localparam int HI_W = ADDR_W - DATA_W;

    for (genvar g = 0; g < NUM_OFS_REGS; g++) begin : g_reg
        localparam int W = (g % 2 == 0) ? DATA_W : HI_W;
        localparam logic [DATA_W-1:0] RST_V = (g % 2 == 0) ? DATA_W'(DEF_OFS) : '0;
        logic [W-1:0] q;

        // Load this slot when it is selected by the pointer.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_V[W-1:0];
            else if (we && (sel == ofs_sel_e'(g)))
                q <= din[W-1:0];
        end

        assign regs[g] = DATA_W'(q);
    end
endmodule

// File: rtl/ofs_readback.sv
// Read-domain readback register. Assumes the offset registers are static
// while they are being read back, so it samples them directly.
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 take,
    input  ofs_sel_e                             sel,
    input  logic [NUM_OFS_REGS-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]                    dout,
    output logic                                 dout_vld
);
    // Capture the selected register on an accepted read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= take;
            if (take)
                dout <= regs[sel];
        end
    end
endmodule

// File: rtl/flag_ofs_regfile.sv
// Sequential flag-offset register file. Decodes the access strobes, keeps
// one shared pointer, and assembles the two thresholds.
// Assumes: wr_clk and rd_clk are the same clock during offset access;
// ADDR_W lies between DATA_W+1 and 2*DATA_W.
module flag_ofs_regfile
    import ofs_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 17,
    parameter int DEF_OFS = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic     wr_req, rd_req, rd_take, step;
    ofs_sel_e sel;
    logic [NUM_OFS_REGS-1:0][DATA_W-1:0] regs;

    // Access decode: a write beats a simultaneous read.
    always_comb begin
        wr_req  = !ld_n && !wen1_n;
        rd_req  = !ld_n && !ren1_n && !ren2_n;
        rd_take = rd_req && !wr_req;
        step    = wr_req || rd_req;
    end

    ofs_seq_ptr u_ptr (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .step  (step),
        .sel   (sel)
    );

    ofs_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_bank (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .we    (wr_req),
        .sel   (sel),
        .din   (din),
        .regs  (regs)
    );

    ofs_readback #(.DATA_W(DATA_W)) u_rb (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .take     (rd_take),
        .sel      (sel),
        .regs     (regs),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    // Threshold assembly: high part above low part.
    assign ae_off = {regs[SEL_AE_HI][HI_W-1:0], regs[SEL_AE_LO]};
    assign af_off = {regs[SEL_AF_HI][HI_W-1:0], regs[SEL_AF_LO]};
endmodule

// File: rtl/ofs_regfile_chk.sv
// Port-level properties of the flag-offset register file.
module ofs_regfile_chk #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 17
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              wen1_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld,
    input logic [ADDR_W-1:0] ae_off,
    input logic [ADDR_W-1:0] af_off
);
    a_r4_vld_after_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!ld_n && !ren1_n && !ren2_n && wen1_n) |=> dout_vld);

    a_r9_write_wins: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!ld_n && !wen1_n) |=> (!dout_vld && $stable(dout)));

    a_r10_dout_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(!ld_n && !ren1_n && !ren2_n && wen1_n) |=> (!dout_vld && $stable(dout)));

    a_r3_idle_no_change: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ld_n |=> ($stable(ae_off) && $stable(af_off)));

    a_r2_one_reg_per_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!ld_n && !wen1_n) |=> ($stable(ae_off) || $stable(af_off)));
endmodule

bind flag_ofs_regfile ofs_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_flag_ofs_regfile.sv
module tb_flag_ofs_regfile;
    localparam int DW = 9;
    localparam int AW = 17;
    localparam int HIM = (1 << (AW - DW)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0, ld_n = 1'b1, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_vld;
    logic [AW-1:0] ae_off, af_off;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    int mdl [4];
    int mptr = 0, edout = 0, evld = 0;

    always #10 clk = ~clk;

    flag_ofs_regfile #(.DATA_W(DW), .ADDR_W(AW), .DEF_OFS(7)) dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .dout(dout),
        .dout_vld(dout_vld), .ae_off(ae_off), .af_off(af_off));

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, update the model at the edge, compare at negedge.
    task automatic step(string tag, bit r, bit l, bit w, bit e1, bit e2, int d);
        bit wr, rd;
        rst_n = r; ld_n = l; wen1_n = w; ren1_n = e1; ren2_n = e2; din = DW'(d);
        @(posedge clk);
        wr = !l && !w;
        rd = !l && !e1 && !e2;
        if (!r) begin
            mdl[0] = 7; mdl[1] = 0; mdl[2] = 7; mdl[3] = 0;
            mptr = 0; edout = 0; evld = 0;
        end else if (wr) begin
            mdl[mptr] = (mptr % 2 == 0) ? (d & 511) : (d & HIM);
            mptr = (mptr + 1) % 4; evld = 0;
        end else if (rd) begin
            edout = mdl[mptr]; evld = 1; mptr = (mptr + 1) % 4;
        end else begin
            evld = 0;
        end
        @(negedge clk);
        chk(tag, "dout", int'(dout), edout);
        chk(tag, "dout_vld", int'(dout_vld), evld);
        chk(tag, "ae_off", int'(ae_off), (mdl[1] << DW) | mdl[0]);
        chk(tag, "af_off", int'(af_off), (mdl[3] << DW) | mdl[2]);
    endtask

    task automatic wr_op(string tag, int d);  step(tag, 1, 0, 0, 1, 1, d); endtask
    task automatic rd_op(string tag);         step(tag, 1, 0, 1, 0, 0, 0); endtask
    task automatic idle(string tag);          step(tag, 1, 1, 1, 1, 1, 0); endtask

    initial begin
        @(negedge clk);
        // R1: defaults after reset
        step("R1", 0, 1, 1, 1, 1, 0);
        step("R1", 0, 0, 0, 0, 0, 9'h1AA);
        idle("R1");
        // R5/R1: read all four defaults, then wrap
        for (int i = 0; i < 5; i++) rd_op("R5");
        idle("R10");
        // pointer now at 1; read 3 more to return to 0
        for (int i = 0; i < 3; i++) rd_op("R5");
        // R2/R7/R8: five writes, fifth wraps to almost-empty low
        wr_op("R2", 9'h011);
        wr_op("R8", 9'h1FF);
        wr_op("R7", 9'h0A5);
        wr_op("R7", 9'h003);
        wr_op("R2", 9'h022);
        // R3: write enable without strobe, strobe without enables
        step("R3", 1, 1, 0, 1, 1, 9'h155);
        step("R3", 1, 0, 1, 1, 1, 9'h155);
        // R6: partial write, release strobe, resume
        wr_op("R6", 9'h005);
        idle("R6"); idle("R6"); idle("R6");
        wr_op("R6", 9'h100);
        rd_op("R6");
        // R4: only one read enable, or no strobe
        step("R4", 1, 0, 1, 0, 1, 0);
        step("R4", 1, 0, 1, 1, 0, 0);
        step("R4", 1, 1, 1, 0, 0, 0);
        rd_op("R4");
        // R9: read and write together; then read to see pointer moved once
        step("R9", 1, 0, 0, 0, 0, 9'h0C3);
        rd_op("R9");
        rd_op("R5");
        wr_op("R5", 9'h0E1);
        rd_op("R5");
        idle("R10");
        // R1: reset again mid-run
        step("R1", 0, 0, 0, 1, 1, 9'h077);
        rd_op("R1");
        idle("R1");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule